// File: doc/BRIEF.md
# Hot-Flow Isolation Classifier with Ternary Line Matching

This block sits at one switch port. It decides, for each arriving packet, whether the packet belongs to a congested traffic tree. If it does, the packet goes to a hot queue. Otherwise it goes to the shared cold queue. The block holds a small set of tracking lines. Each line records a congestion root identifier, a ternary pattern over the destination field, a hop count and the output port leading toward the root. Each valid line owns exactly one hot queue, numbered by the line index.

Lines are created in two ways. The first is a local congestion report, which is accepted only while the cold queue occupancy is at or above a high mark. The second is a notification arriving from a downstream port. Each new line sends one notification upstream, with the hop count raised by one, so the isolation spreads toward the sources. A later notification for a root that already has a line rewrites that line's pattern and does not take a second line. A line is released once its hot queue has drained and its idle timer has run out. The queue storage itself lives outside the block.

Top module: `hotflow_classifier`

## Requirements
- R1: A valid line matches a destination when every destination bit whose care bit is 1 equals the line's value bit. Bits whose care bit is 0 are ignored. With `pkt_vld` high and a match, `q_hot` is 1, and `q_line` and `q_port` give the line index and the line's stored output port, in the same cycle.
- R2: When `pkt_vld` is low, or no valid line matches, `q_hot`, `q_line` and `q_port` are all 0 (cold queue).
- R3: When several valid lines match, the lowest-numbered one is selected.
- R4: A notification (`ntf_vld`) whose root is not held by any valid line writes its root, value, care, hop and port into the lowest-numbered free line. Packets are steered by that line from the next cycle on.
- R5: One cycle after any allocation, `up_vld` is high for one cycle. It carries the new line's root, value and care, and its hop count plus one, saturating at 7. `up_vld` is low in every other cycle.
- R6: A local report (`det_vld`) allocates a line with hop count 0 only while `cold_occ` is at least the high mark (12 by default). Below the mark it is ignored.
- R7: An event whose root is already held rewrites that line's value and care, reloads its timer, and keeps its hop and port. It allocates nothing and raises no `up_vld`.
- R8: With all four lines valid, a new root allocates nothing and raises no `up_vld`, and its destinations stay in the cold queue.
- R9: When `ntf_vld` and `det_vld` arrive in the same cycle, only the notification is taken and the local report is dropped.
- R10: A line's timer loads HOLD (6) on allocation, on a rewrite and on each packet steered to it. Otherwise it counts down to 0. The line is freed at the first clock edge where its timer is 0, its `hot_empty` bit is 1, and no packet is being steered to it.
- R11: After reset no line is valid, so every packet goes cold, and `up_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_vld | input | 1 | A packet destination is presented |
| pkt_dst | input | 6 | Packet destination |
| q_hot | output | 1 | 1: hot queue of `q_line`; 0: cold queue |
| q_line | output | 2 | Selected line / hot queue index |
| q_port | output | 2 | Output port stored in the selected line |
| det_vld | input | 1 | Local congestion report |
| det_root | input | 4 | Root identifier of the local report |
| det_val | input | 6 | Pattern value bits of the local report |
| det_care | input | 6 | Pattern care bits of the local report (1 = compare) |
| det_port | input | 2 | Output port of the local report |
| cold_occ | input | 4 | Cold queue occupancy |
| ntf_vld | input | 1 | Notification from downstream |
| ntf_root | input | 4 | Notified root identifier |
| ntf_val | input | 6 | Notified pattern value bits |
| ntf_care | input | 6 | Notified pattern care bits |
| ntf_hop | input | 3 | Notified hop count |
| ntf_port | input | 2 | Port the notification arrived on |
| hot_empty | input | 4 | Per-line hot queue empty flags |
| up_vld | output | 1 | Upstream notification pulse |
| up_root | output | 4 | Upstream notification root |
| up_val | output | 6 | Upstream notification value bits |
| up_care | output | 6 | Upstream notification care bits |
| up_hop | output | 3 | Upstream notification hop count |

## Verification
The bench targets the following corner cases and the failure each one would expose.
- Overlapping patterns. A design with inverted priority would pick the higher line.
- Pattern widening on a held root. A design that did not check for a held root would take a second line and emit a spurious upstream pulse. A design that kept the old pattern would keep steering a destination that should now go cold.
- A local report just below and at the high mark. This catches an off-by-one comparison.
- A notification and a local report in the same cycle.
- A table that is already full. A design without the full check would overwrite a line.
- Release timing, counted in exact cycles. A design that freed a non-empty queue, or freed one cycle early, would misroute the probe packet.

A long seeded random phase then compares every output each cycle against a reference model.

// File: rtl/hotflow_classifier.sv
module hotflow_classifier #(
  parameter int DST_W   = 6,
  parameter int LINES   = 4,
  parameter int ROOT_W  = 4,
  parameter int HOP_W   = 3,
  parameter int PORT_W  = 2,
  parameter int OCC_W   = 4,
  parameter int TMR_W   = 4,
  parameter int HOLD    = 6,
  parameter int HI_MARK = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_vld,
  input  logic [DST_W-1:0]  pkt_dst,
  output logic              q_hot,
  output logic [$clog2(LINES)-1:0] q_line,
  output logic [PORT_W-1:0] q_port,
  input  logic              det_vld,
  input  logic [ROOT_W-1:0] det_root,
  input  logic [DST_W-1:0]  det_val,
  input  logic [DST_W-1:0]  det_care,
  input  logic [PORT_W-1:0] det_port,
  input  logic [OCC_W-1:0]  cold_occ,
  input  logic              ntf_vld,
  input  logic [ROOT_W-1:0] ntf_root,
  input  logic [DST_W-1:0]  ntf_val,
  input  logic [DST_W-1:0]  ntf_care,
  input  logic [HOP_W-1:0]  ntf_hop,
  input  logic [PORT_W-1:0] ntf_port,
  input  logic [LINES-1:0]  hot_empty,
  output logic              up_vld,
  output logic [ROOT_W-1:0] up_root,
  output logic [DST_W-1:0]  up_val,
  output logic [DST_W-1:0]  up_care,
  output logic [HOP_W-1:0]  up_hop
);
  localparam int IDX_W = $clog2(LINES);
  localparam logic [TMR_W-1:0] RELOAD = TMR_W'(HOLD);
  localparam logic [HOP_W-1:0] HOP_MAX = '1;

  logic [LINES-1:0]  vld;
  logic [ROOT_W-1:0] root [LINES];
  logic [DST_W-1:0]  val  [LINES];
  logic [DST_W-1:0]  care [LINES];
  logic [HOP_W-1:0]  hop  [LINES];
  logic [PORT_W-1:0] port [LINES];
  logic [TMR_W-1:0]  tmr  [LINES];

  logic [LINES-1:0] hit, held;
  logic [IDX_W-1:0] hit_idx, held_idx, free_idx;

  always_comb begin
    hit_idx = '0; held_idx = '0; free_idx = '0;
    for (int i = LINES-1; i >= 0; i--) begin
      hit[i]  = vld[i] && (((pkt_dst ^ val[i]) & care[i]) == '0);
      held[i] = vld[i] && (root[i] == ev_root);
      if (hit[i])  hit_idx  = IDX_W'(i);
      if (held[i]) held_idx = IDX_W'(i);
      if (!vld[i]) free_idx = IDX_W'(i);
    end
  end

  assign q_hot  = pkt_vld && (|hit);
  assign q_line = q_hot ? hit_idx : '0;
  assign q_port = q_hot ? port[hit_idx] : '0;

  logic              ev_go;
  logic [ROOT_W-1:0] ev_root;
  logic [DST_W-1:0]  ev_val, ev_care;
  logic [HOP_W-1:0]  ev_hop;
  logic [PORT_W-1:0] ev_port;

  assign ev_go   = ntf_vld || (det_vld && (cold_occ >= OCC_W'(HI_MARK)));
  assign ev_root = ntf_vld ? ntf_root : det_root;
  assign ev_val  = ntf_vld ? ntf_val  : det_val;
  assign ev_care = ntf_vld ? ntf_care : det_care;
  assign ev_hop  = ntf_vld ? ntf_hop  : '0;
  assign ev_port = ntf_vld ? ntf_port : det_port;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      up_vld <= 1'b0;
      up_root <= '0; up_val <= '0; up_care <= '0; up_hop <= '0;
      for (int i = 0; i < LINES; i++) begin
        root[i] <= '0; val[i] <= '0; care[i] <= '0;
        hop[i] <= '0; port[i] <= '0; tmr[i] <= '0;
      end
    end else begin
      up_vld <= 1'b0;
      for (int i = 0; i < LINES; i++) begin
        if (vld[i]) begin
          if (q_hot && hit_idx == IDX_W'(i)) tmr[i] <= RELOAD;
          else if (tmr[i] != '0)            tmr[i] <= tmr[i] - 1'b1;
          else if (hot_empty[i])             vld[i] <= 1'b0;
        end
      end
      if (ev_go) begin
        if (|held) begin
          val[held_idx]  <= ev_val;
          care[held_idx] <= ev_care;
          tmr[held_idx]  <= RELOAD;
          vld[held_idx]  <= 1'b1;
        end else if (!(&vld)) begin
          vld[free_idx]  <= 1'b1;
          root[free_idx] <= ev_root;
          val[free_idx]  <= ev_val;
          care[free_idx] <= ev_care;
          hop[free_idx]  <= ev_hop;
          port[free_idx] <= ev_port;
          tmr[free_idx]  <= RELOAD;
          up_vld  <= 1'b1;
          up_root <= ev_root;
          up_val  <= ev_val;
          up_care <= ev_care;
          up_hop  <= (ev_hop == HOP_MAX) ? HOP_MAX : ev_hop + 1'b1;
        end
      end
    end
  end

  // R5
  up_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_vld |-> $past(ntf_vld || det_vld));

  // R5
  up_hop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_vld && $past(ntf_vld)) |->
      (up_hop == (($past(ntf_hop) == HOP_MAX) ? HOP_MAX : $past(ntf_hop) + 1'b1)));

  // R7
  no_dup_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_vld |-> !$past(|held));

  // R2
  empty_cold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld == '0) |-> !q_hot);

  for (genvar g = 0; g < LINES; g++) begin : g_free
    // R10
    free_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(vld[g]) |-> ($past(hot_empty[g]) && $past(tmr[g]) == '0));
  end
endmodule

// File: tb/hotflow_classifier_test.sv
`timescale 1ns/1ps
module hotflow_classifier_test;
  localparam int HOLD = 6;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic pkt_vld; logic [5:0] pkt_dst;
  logic q_hot; logic [1:0] q_line, q_port;
  logic det_vld; logic [3:0] det_root; logic [5:0] det_val, det_care; logic [1:0] det_port;
  logic [3:0] cold_occ;
  logic ntf_vld; logic [3:0] ntf_root; logic [5:0] ntf_val, ntf_care; logic [2:0] ntf_hop; logic [1:0] ntf_port;
  logic [3:0] hot_empty;
  logic up_vld; logic [3:0] up_root; logic [5:0] up_val, up_care; logic [2:0] up_hop;

  hotflow_classifier uut (.*);

  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  logic       m_vld  [4];
  logic [3:0] m_root [4];
  logic [5:0] m_val  [4], m_care [4];
  logic [2:0] m_hop  [4];
  logic [1:0] m_port [4];
  int         m_tmr  [4];
  logic m_up; logic [3:0] m_up_root; logic [5:0] m_up_val, m_up_care; logic [2:0] m_up_hop;
  logic obs_hot, obs_up; logic [1:0] obs_line, obs_port; logic [2:0] obs_hop;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic int m_first(logic [5:0] d);
    for (int i = 0; i < 4; i++)
      if (m_vld[i] && (((d ^ m_val[i]) & m_care[i]) == 0)) return i;
    return -1;
  endfunction

  function automatic int m_count(logic [5:0] d);
    int n = 0;
    for (int i = 0; i < 4; i++)
      if (m_vld[i] && (((d ^ m_val[i]) & m_care[i]) == 0)) n++;
    return n;
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 4; i++) begin m_vld[i] = 0; m_tmr[i] = 0; end
    m_up = 0;
  endtask

  task automatic idle();
    pkt_vld = 0; pkt_dst = 0; det_vld = 0; det_root = 0; det_val = 0; det_care = 0;
    det_port = 0; cold_occ = 0; ntf_vld = 0; ntf_root = 0; ntf_val = 0; ntf_care = 0;
    ntf_hop = 0; ntf_port = 0;
  endtask

  task automatic tick();
    int e, h, f;
    bit ev, e_hot;
    logic [3:0] er; logic [5:0] ev_v, ev_c; logic [2:0] eh; logic [1:0] ep;
    string tag;
    #1;
    e = pkt_vld ? m_first(pkt_dst) : -1;
    e_hot = (e >= 0);
    tag = !e_hot ? "R2" : (m_count(pkt_dst) > 1 ? "R3" : "R1");
    obs_hot = q_hot; obs_line = q_line; obs_port = q_port;
    chk(q_hot == e_hot, tag, "q_hot", q_hot, e_hot);
    chk(q_line == (e_hot ? 2'(e) : 2'd0), tag, "q_line", q_line, e_hot ? e : 0);
    chk(q_port == (e_hot ? m_port[e] : 2'd0), tag, "q_port", q_port, e_hot ? m_port[e] : 0);
    ev = ntf_vld || (det_vld && cold_occ >= 12);
    er = ntf_vld ? ntf_root : det_root; ev_v = ntf_vld ? ntf_val : det_val;
    ev_c = ntf_vld ? ntf_care : det_care; eh = ntf_vld ? ntf_hop : 3'd0;
    ep = ntf_vld ? ntf_port : det_port;
    h = -1; f = -1;
    for (int i = 3; i >= 0; i--) begin
      if (m_vld[i] && m_root[i] == er) h = i;
      if (!m_vld[i]) f = i;
    end
    for (int i = 0; i < 4; i++)
      if (m_vld[i]) begin
        if (e == i) m_tmr[i] = HOLD;
        else if (m_tmr[i] != 0) m_tmr[i]--;
        else if (hot_empty[i]) m_vld[i] = 0;
      end
    m_up = 0;
    if (ev) begin
      if (h >= 0) begin
        m_val[h] = ev_v; m_care[h] = ev_c; m_tmr[h] = HOLD; m_vld[h] = 1;
      end else if (f >= 0) begin
        m_vld[f] = 1; m_root[f] = er; m_val[f] = ev_v; m_care[f] = ev_c;
        m_hop[f] = eh; m_port[f] = ep; m_tmr[f] = HOLD;
        m_up = 1; m_up_root = er; m_up_val = ev_v; m_up_care = ev_c;
        m_up_hop = (eh == 3'd7) ? 3'd7 : eh + 3'd1;
      end
    end
    @(posedge clk); @(negedge clk);
    cycles++;
    obs_up = up_vld; obs_hop = up_hop;
    chk(up_vld == m_up, "R5", "up_vld", up_vld, m_up);
    if (m_up && up_vld) begin
      chk(up_root == m_up_root, "R5", "up_root", up_root, m_up_root);
      chk(up_val == m_up_val, "R5", "up_val", up_val, m_up_val);
      chk(up_care == m_up_care, "R5", "up_care", up_care, m_up_care);
      chk(up_hop == m_up_hop, "R5", "up_hop", up_hop, m_up_hop);
    end
  endtask

  task automatic probe(logic [5:0] d);
    idle(); pkt_vld = 1; pkt_dst = d; tick(); idle();
  endtask

  task automatic notify(logic [3:0] r, logic [5:0] v, logic [5:0] c, logic [2:0] hp, logic [1:0] p);
    idle(); ntf_vld = 1; ntf_root = r; ntf_val = v; ntf_care = c; ntf_hop = hp; ntf_port = p;
    tick(); idle();
  endtask

  task automatic do_reset();
    idle(); hot_empty = 4'b0000; rst_n = 0; m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=0", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R11
    probe(6'h00);
    chk(obs_hot == 0, "R11", "q_hot after reset", obs_hot, 0);
    chk(obs_up == 0, "R11", "up_vld after reset", obs_up, 0);

    notify(4'd3, 6'b000000, 6'b001100, 3'd1, 2'd2);
    chk(obs_up == 1, "R4", "alloc pulse", obs_up, 1);
    chk(obs_hop == 3'd2, "R5", "hop+1", obs_hop, 2);
    probe(6'b110011);
    chk(obs_hot == 1 && obs_line == 0 && obs_port == 2, "R4", "new line steers", obs_hot, 1);
    probe(6'b000100);
    chk(obs_hot == 0, "R1", "care bit mismatch", obs_hot, 0);

    notify(4'd3, 6'b000000, 6'b001111, 3'd1, 2'd2);
    chk(obs_up == 0, "R7", "rewrite no pulse", obs_up, 1'b0);
    probe(6'b110011);
    chk(obs_hot == 0, "R7", "widened miss", obs_hot, 0);
    probe(6'b110000);
    chk(obs_hot == 1 && obs_line == 0, "R7", "widened hit", obs_line, 0);

    notify(4'd5, 6'b110000, 6'b110000, 3'd0, 2'd1);
    probe(6'b110000);
    chk(obs_hot == 1 && obs_line == 0, "R3", "lowest line wins", obs_line, 0);
    probe(6'b111111);
    chk(obs_hot == 1 && obs_line == 1 && obs_port == 1, "R1", "line1 hit", obs_line, 1);

    idle(); det_vld = 1; det_root = 4'd7; det_val = 6'b000001; det_care = 6'b111111;
    det_port = 2'd3; cold_occ = 4'd11; tick();
    chk(obs_up == 0, "R6", "below mark", obs_up, 0);
    probe(6'b000001);
    chk(obs_hot == 0, "R6", "below mark no line", obs_hot, 0);
    idle(); det_vld = 1; det_root = 4'd7; det_val = 6'b000001; det_care = 6'b111111;
    det_port = 2'd3; cold_occ = 4'd12; tick();
    chk(obs_up == 1 && obs_hop == 3'd1, "R6", "at mark hop1", obs_hop, 1);
    probe(6'b000001);
    chk(obs_hot == 1 && obs_line == 2, "R6", "local line hit", obs_line, 2);

    idle(); ntf_vld = 1; ntf_root = 4'd8; ntf_val = 6'b000010; ntf_care = 6'b111111;
    ntf_hop = 3'd7; det_vld = 1; det_root = 4'd9; det_val = 6'b000011; det_care = 6'b111111;
    cold_occ = 4'd15; tick();
    chk(obs_hop == 3'd7, "R5", "hop saturates", obs_hop, 7);
    probe(6'b000011);
    chk(obs_hot == 0, "R9", "local dropped", obs_hot, 0);
    probe(6'b000010);
    chk(obs_hot == 1 && obs_line == 3, "R9", "notify taken", obs_line, 3);

    notify(4'd10, 6'b000100, 6'b111111, 3'd0, 2'd0);
    chk(obs_up == 0, "R8", "full no pulse", obs_up, 0);
    probe(6'b000100);
    chk(obs_hot == 0, "R8", "full stays cold", obs_hot, 0);

    probe(6'b000001);
    hot_empty = 4'b0100;
    repeat (HOLD) tick();
    probe(6'b000001);
    chk(obs_hot == 1 && obs_line == 2, "R10", "held until expiry", obs_line, 2);
    repeat (HOLD + 1) tick();
    probe(6'b000001);
    chk(obs_hot == 0, "R10", "freed after drain", obs_hot, 0);
    probe(6'b110000);
    chk(obs_hot == 1 && obs_line == 0, "R10", "non-empty kept", obs_line, 0);
    notify(4'd10, 6'b000100, 6'b111111, 3'd0, 2'd0);
    chk(obs_up == 1, "R4", "freed line reused", obs_up, 1);
    probe(6'b000100);
    chk(obs_hot == 1 && obs_line == 2, "R4", "reused index", obs_line, 2);

    do_reset();
    void'($urandom(32'd1234));
    for (int n = 0; n < 4000; n++) begin
      int k;
      idle();
      hot_empty = 4'($urandom);
      if ($urandom % 2) begin
        pkt_vld = 1; k = $urandom % 4;
        pkt_dst = 6'($urandom);
        if (($urandom % 2) && m_vld[k])
          pkt_dst = (m_val[k] & m_care[k]) | (6'($urandom) & ~m_care[k]);
      end
      if ($urandom % 6 == 0) begin
        ntf_vld = 1; ntf_root = 4'($urandom % 6); ntf_val = 6'($urandom);
        ntf_care = 6'($urandom) | 6'($urandom); ntf_hop = 3'($urandom); ntf_port = 2'($urandom);
      end
      if ($urandom % 6 == 0) begin
        det_vld = 1; det_root = 4'($urandom % 6); det_val = 6'($urandom);
        det_care = 6'($urandom) | 6'($urandom); det_port = 2'($urandom);
      end
      cold_occ = 4'($urandom);
      tick();
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule